// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block puts a 256-entry file of 8-bit configuration registers behind a two-byte I/O window. The even address of the window is the index (pointer) register: writing it selects an entry, and reading it returns the current selection. The odd address is the data register: reading it returns the selected entry, and writing it updates that entry. Each update passes through per-index rules. Entries below a read-only limit cannot be changed and always read zero. Two locked entries accept only one specific byte and keep their value for any other write. All other entries in the upper range take whatever is written.

The window answers only while one enable bit is set in a separate bridge control byte. That byte is written through its own configuration port at a fixed offset. While the window is closed, reads return all ones, no acknowledge is given, and writes have no effect. A synchronous active-high reset closes the window, clears the index, and loads fixed defaults into the file.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the index is 0x00 and the window is closed. Entry 0xE0 reads 0x3C, 0xE2 reads 0x03, 0xE3 reads 0xFC, 0xE6 reads 0xDE, 0xE7 reads 0xFE and 0xE8 reads 0xBE. Every other entry reads 0x00.
- R2: The window decodes exactly two byte addresses: BASE_ADDR (0x3F0, the index) and BASE_ADDR+1 (the data). Any other address gives no acknowledge and reads 0xFF.
- R3: A write to the index address stores bus_wdata as the index. A read of the data address returns the entry the index selects, and a read of the index address returns the index. Both come back in the same cycle as the read strobe.
- R4: The index keeps its value across any number of data reads and writes. It changes only on an acknowledged write to the index address.
- R5: An acknowledged data write to an entry at or above 0xE0, other than 0xE7 and 0xE8, stores the byte. The new value reads back from the next cycle on.
- R6: Entries below 0xE0 are read-only. A data write to one of them is acknowledged but dropped, and such an entry always reads 0x00.
- R7: Entry 0xE7 accepts a data write only when the byte is 0xFE. Any other byte leaves the entry unchanged.
- R8: Entry 0xE8 accepts a data write only when the byte is 0xBE. Any other byte leaves the entry unchanged.
- R9: The window is open only while bit 1 of the bridge control byte at offset 0x85 is 1. Writes to other bridge offsets do not change it. While the window is closed, reads give 0xFF, nothing is acknowledged, and index and data writes have no effect.
- R10: Only single-byte accesses (bus_size = 1) are decoded. An access of any other size gets no acknowledge and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0xFF when not acknowledged |
| bus_ack | output | 1 | Access accepted by the window |
| brg_we | input | 1 | Bridge control byte write strobe |
| brg_off | input | 8 | Bridge configuration offset |
| brg_wdata | input | 8 | Bridge configuration write data |

## Verification
The bench walks the index through all 256 entries right after reset, so every default and every read-only zero is seen at least once. Plain data writes to a free upper entry are contrasted with writes to the read-only range and with wrong and right bytes at both locked entries; this separates the store path from each filter. Accesses at a neighbouring address, of a wider size, and while the window is closed are each followed by reads with the window open. That shows whether any of them leaked into the index or the file. A second reset mid-run checks that earlier writes are cleared.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Entries that accept a single key value only
    localparam byte_t LOCK_A_IDX = 8'hE7;
    localparam byte_t LOCK_A_VAL = 8'hFE;
    localparam byte_t LOCK_B_IDX = 8'hE8;
    localparam byte_t LOCK_B_VAL = 8'hBE;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_INDEX = 2'd1,
        SEL_DATA  = 2'd2
    } sel_e;

    typedef struct packed {
        logic hit;
        logic wr;
        logic rd;
        sel_e sel;
    } acc_t;

    // Power-on content of one entry
    function automatic byte_t dflt_value(input byte_t idx);
        byte_t v;
        case (idx)
            8'hE0:   v = 8'h3C;
            8'hE2:   v = 8'h03;
            8'hE3:   v = 8'hFC;
            8'hE6:   v = 8'hDE;
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    // Per-index write filter
    function automatic logic write_ok(input byte_t idx, input byte_t val,
                                      input byte_t ro_limit);
        logic ok;
        if (idx < ro_limit)          ok = 1'b0;
        else if (idx == LOCK_A_IDX)  ok = (val == LOCK_A_VAL);
        else if (idx == LOCK_B_IDX)  ok = (val == LOCK_B_VAL);
        else                         ok = 1'b1;
        return ok;
    endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [2:0]        size,
    input  logic              win_en,
    output acc_t              acc
);
    localparam logic [ADDR_W-2:0] PAIR = BASE_ADDR[ADDR_W-1:1];

    logic pair_match;
    assign pair_match = (addr[ADDR_W-1:1] == PAIR);

    always_comb begin
        acc     = '0;
        acc.wr  = wr;
        acc.rd  = rd;
        acc.hit = win_en && pair_match && (size == 3'd1) && (wr ^ rd);
        if (!acc.hit)      acc.sel = SEL_NONE;
        else if (addr[0])  acc.sel = SEL_DATA;
        else               acc.sel = SEL_INDEX;
    end
endmodule

// File: rtl/cfgp_bridge_ctl.sv
module cfgp_bridge_ctl
    import cfgp_pkg::*;
#(
    parameter byte_t EN_OFFSET = 8'h85,
    parameter int    EN_BIT    = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  brg_we,
    input  byte_t brg_off,
    input  byte_t brg_wdata,
    output logic  win_en
);
    byte_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)                                  ctl_q <= '0;
        else if (brg_we && brg_off == EN_OFFSET)  ctl_q <= brg_wdata;
    end

    assign win_en = ctl_q[EN_BIT];

    logic unused_ctl;
    assign unused_ctl = ^ctl_q;

    // R9: the window opens only through a write at the enable offset
    p_open_src_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(win_en) |-> $past(brg_we) && $past(brg_off) == EN_OFFSET);
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter byte_t RO_LIMIT = 8'hE0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t idx,
    input  byte_t wdata,
    output byte_t rd_data
);
    localparam int NUM_RW = 256 - int'(RO_LIMIT);
    localparam int SLOT_W = (NUM_RW > 1) ? $clog2(NUM_RW) : 1;

    byte_t stor [NUM_RW];
    byte_t off;
    logic  commit;

    assign off    = idx - RO_LIMIT;
    assign commit = wr_en && write_ok(idx, wdata, RO_LIMIT);

    for (genvar k = 0; k < NUM_RW; k++) begin : g_entry
        localparam byte_t ENTRY_IDX = byte_t'(k + int'(RO_LIMIT));
        always_ff @(posedge clk) begin
            if (rst)                            stor[k] <= dflt_value(ENTRY_IDX);
            else if (commit && idx == ENTRY_IDX) stor[k] <= wdata;
        end
    end

    assign rd_data = (idx < RO_LIMIT) ? '0 : stor[off[SLOT_W-1:0]];

    logic unused_off;
    assign unused_off = ^off;

    // R7 / R8: locked entries never leave their key value
    if (LOCK_A_IDX >= RO_LIMIT) begin : g_chk_a
        p_lock_a_r7: assert property (@(posedge clk) disable iff (rst)
            stor[int'(LOCK_A_IDX) - int'(RO_LIMIT)] == LOCK_A_VAL);
    end
    if (LOCK_B_IDX >= RO_LIMIT) begin : g_chk_b
        p_lock_b_r8: assert property (@(posedge clk) disable iff (rst)
            stor[int'(LOCK_B_IDX) - int'(RO_LIMIT)] == LOCK_B_VAL);
    end

    // R6: read-only range reads zero even right after a write attempt
    p_ro_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx < RO_LIMIT) |=> (idx >= RO_LIMIT) || rd_data == '0);
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfgp_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
    parameter byte_t             RO_LIMIT  = 8'hE0,
    parameter byte_t             EN_OFFSET = 8'h85,
    parameter int                EN_BIT    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_size,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_ack,
    input  logic              brg_we,
    input  logic [7:0]        brg_off,
    input  logic [7:0]        brg_wdata
);
    logic  win_en;
    acc_t  acc;
    byte_t cur_idx;
    byte_t rf_data;
    logic  idx_wr;
    logic  data_wr;

    cfgp_bridge_ctl #(.EN_OFFSET(EN_OFFSET), .EN_BIT(EN_BIT)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .brg_we    (brg_we),
        .brg_off   (brg_off),
        .brg_wdata (brg_wdata),
        .win_en    (win_en)
    );

    cfgp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .size   (bus_size),
        .win_en (win_en),
        .acc    (acc)
    );

    assign idx_wr  = acc.hit && acc.wr && acc.sel == SEL_INDEX;
    assign data_wr = acc.hit && acc.wr && acc.sel == SEL_DATA;

    always_ff @(posedge clk) begin
        if (rst)         cur_idx <= '0;
        else if (idx_wr) cur_idx <= bus_wdata;
    end

    cfgp_regfile #(.RO_LIMIT(RO_LIMIT)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (data_wr),
        .idx     (cur_idx),
        .wdata   (bus_wdata),
        .rd_data (rf_data)
    );

    always_comb begin
        bus_rdata = 8'hFF;
        if (acc.hit && acc.rd)
            bus_rdata = (acc.sel == SEL_INDEX) ? cur_idx : rf_data;
    end

    assign bus_ack = acc.hit;

    // R1: index comes out of reset as zero
    p_idx_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cur_idx == '0);
    // R4: index moves only on an index-address write
    p_idx_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !idx_wr |=> $stable(cur_idx));
    // R9: no acknowledge and all-ones read data while closed
    p_closed_ack_r9: assert property (@(posedge clk) disable iff (rst)
        !win_en |-> !bus_ack && bus_rdata == 8'hFF);
    // R10: acknowledged accesses are single-byte
    p_single_byte_r10: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> bus_size == 3'd1);
endmodule

// File: tb/cfg_index_port_tb.sv
module cfg_index_port_tb;
    localparam int         CLK_PERIOD = 10;
    localparam logic [15:0] BASE      = 16'h03F0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_size = 3'd1;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_ack;
    logic        brg_we = 1'b0;
    logic [7:0]  brg_off = '0;
    logic [7:0]  brg_wdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_port u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .brg_we(brg_we),
        .brg_off(brg_off), .brg_wdata(brg_wdata)
    );

    // Scoreboard
    typedef struct packed {
        logic       ack;
        logic       chk_rd;
        logic [7:0] rd;
    } exp_t;
    exp_t  exp_q [$];
    string tag_q [$];
    event  mon_ev;
    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;

    // Reference model built from the requirements
    logic [7:0] mdl [256];
    logic [7:0] mdl_idx;
    logic       mdl_en;

    function automatic logic [7:0] ref_default(input logic [7:0] i);
        case (i)
            8'hE0: return 8'h3C;
            8'hE2: return 8'h03;
            8'hE3: return 8'hFC;
            8'hE6: return 8'hDE;
            8'hE7: return 8'hFE;
            8'hE8: return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic ref_accepts(input logic [7:0] i, input logic [7:0] v);
        if (i < 8'hE0) return 1'b0;
        if (i == 8'hE7) return v == 8'hFE;
        if (i == 8'hE8) return v == 8'hBE;
        return 1'b1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) mdl[i] = ref_default(8'(i));
        mdl_idx = 8'h00;
        mdl_en  = 1'b0;
    endtask

    // Monitor: pops one expectation per access and compares
    initial begin
        forever begin
            exp_t  e;
            string t;
            @(mon_ev);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_ack !== e.ack) begin
                errors++;
                $display("FAIL %s ack: actual=%b expected=%b", t, bus_ack, e.ack);
            end
            if (e.chk_rd) begin
                checks++;
                if (bus_rdata !== e.rd) begin
                    errors++;
                    $display("FAIL %s rdata: actual=%02h expected=%02h", t, bus_rdata, e.rd);
                end
            end
        end
    end

    // Driver
    task automatic bus_op(input logic wr, input logic rd, input logic [15:0] a,
                          input logic [2:0] sz, input logic [7:0] wd,
                          input logic eack, input logic chk, input logic [7:0] erd,
                          input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_size = sz; bus_wdata = wd;
        #1;
        e.ack = eack; e.chk_rd = chk; e.rd = erd;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        ->mon_ev;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_size = 3'd1;
    endtask

    task automatic idx_write(input logic [7:0] v, input string tag);
        bus_op(1, 0, BASE, 3'd1, v, mdl_en, 0, 8'h00, tag);
        if (mdl_en) mdl_idx = v;
    endtask

    task automatic data_write(input logic [7:0] v, input string tag);
        bus_op(1, 0, BASE + 16'd1, 3'd1, v, mdl_en, 0, 8'h00, tag);
        if (mdl_en && ref_accepts(mdl_idx, v)) mdl[mdl_idx] = v;
    endtask

    task automatic data_read(input string tag);
        bus_op(0, 1, BASE + 16'd1, 3'd1, 8'h00, mdl_en, 1,
               mdl_en ? mdl[mdl_idx] : 8'hFF, tag);
    endtask

    task automatic idx_read(input string tag);
        bus_op(0, 1, BASE, 3'd1, 8'h00, mdl_en, 1, mdl_en ? mdl_idx : 8'hFF, tag);
    endtask

    task automatic brg_write(input logic [7:0] off, input logic [7:0] v);
        @(negedge clk);
        brg_we = 1'b1; brg_off = off; brg_wdata = v;
        @(posedge clk);
        #1;
        brg_we = 1'b0;
        if (off == 8'h85) mdl_en = v[1];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        model_reset();
        do_reset();

        // R1 / R9: closed after reset
        data_read("R1 R9 closed after reset");
        idx_write(8'hE5, "R9 index write while closed");
        brg_write(8'h84, 8'hFF);
        data_read("R9 other bridge offset keeps window closed");
        brg_write(8'h85, 8'h02);
        idx_read("R1 R9 index is zero and untouched");

        // R1: sweep all defaults
        for (int i = 0; i < 256; i++) begin
            idx_write(8'(i), "R3 index select");
            data_read("R1 default content");
        end

        // R5 / R4
        idx_write(8'hE5, "R3 select free entry");
        data_write(8'h5A, "R5 store");
        data_read("R5 readback");
        data_write(8'hC3, "R5 overwrite");
        data_read("R5 readback second");
        data_read("R4 repeated read");
        idx_read("R4 index kept across data accesses");
        idx_write(8'hE0, "R3 select default entry");
        data_write(8'hA5, "R5 store over default");
        data_read("R5 readback over default");

        // R6
        idx_write(8'h10, "R3 select read-only");
        data_write(8'h77, "R6 write acked and dropped");
        data_read("R6 read-only reads zero");
        idx_write(8'hDF, "R3 select top of read-only range");
        data_write(8'hFF, "R6 write at limit");
        data_read("R6 limit reads zero");

        // R7
        idx_write(8'hE7, "R3 select lock A");
        data_write(8'h00, "R7 wrong key");
        data_read("R7 unchanged after wrong key");
        data_write(8'hFF, "R7 near key");
        data_read("R7 unchanged after near key");
        data_write(8'hFE, "R7 correct key");
        data_read("R7 key value");

        // R8
        idx_write(8'hE8, "R3 select lock B");
        data_write(8'h12, "R8 wrong key");
        data_read("R8 unchanged after wrong key");
        data_write(8'hBF, "R8 near key");
        data_read("R8 unchanged after near key");
        data_write(8'hBE, "R8 correct key");
        data_read("R8 key value");

        // R2: neighbouring addresses
        bus_op(0, 1, BASE + 16'd2, 3'd1, 8'h00, 0, 1, 8'hFF, "R2 above window");
        bus_op(1, 0, BASE - 16'd1, 3'd1, 8'h33, 0, 0, 8'h00, "R2 write below window");
        bus_op(1, 0, BASE ^ 16'h0100, 3'd1, 8'h44, 0, 0, 8'h00, "R2 aliased write");
        idx_read("R2 index untouched by foreign addresses");

        // R10: wider accesses
        idx_write(8'hE5, "R3 reselect free entry");
        bus_op(1, 0, BASE + 16'd1, 3'd2, 8'h99, 0, 0, 8'h00, "R10 word write");
        bus_op(0, 1, BASE + 16'd1, 3'd4, 8'h00, 0, 1, 8'hFF, "R10 dword read");
        bus_op(1, 0, BASE, 3'd0, 8'h22, 0, 0, 8'h00, "R10 zero-size index write");
        data_read("R10 entry unchanged");
        idx_read("R10 index unchanged");

        // R9: close, try writes, reopen
        brg_write(8'h85, 8'h01);
        idx_write(8'h20, "R9 index write closed");
        data_write(8'h11, "R9 data write closed");
        data_read("R9 closed read");
        brg_write(8'h85, 8'hFF);
        idx_read("R9 index survived closed period");
        data_read("R9 entry survived closed period");

        // R1: reset mid-run
        do_reset();
        data_read("R1 closed after second reset");
        brg_write(8'h85, 8'h02);
        idx_read("R1 index cleared");
        idx_write(8'hE5, "R3 select after reset");
        data_read("R1 written entry cleared");
        idx_write(8'hE0, "R3 select default after reset");
        data_read("R1 default restored");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule